// File: doc/BRIEF.md
# Raster Line Timing Unit

This block keeps the scanline count for a 256-line video frame that repeats sixty times a second. A line-rate tick enable comes from the pixel timing elsewhere on the chip. Each tick moves the count forward by one line, and the count wraps to zero at the end of the frame. A frame-start strobe marks that wrap.

A processor reads the raster position through a byte port. The port gives the line number with the two lowest bits cleared. The byte is registered, so it holds steady for a whole read cycle.

The block also drives two interrupt-source lines meant for the edge-sensitive inputs of a parallel interface adapter:
- a square wave taken from one line-address bit;
- a flag that is high over the bottom band of the frame, after the visible area ends.

Top module: `raster_timing`

## Requirements
- R1: While synchronous reset is high at a clock edge, the unit clears itself. After that edge the line number is 0, the readable byte is 0x00 and the frame-start strobe is low.
- R2: At each clock edge where the tick enable is high, the line number goes up by one. When the tick enable is low, the line number stays the same.
- R3: If a tick arrives while the line number is 255, the line number wraps to 0. A frame therefore has 256 lines, numbered 0 to 255.
- R4: The frame-start strobe is high for exactly one clock. That clock is the first one in which the line number is 0 after a wrap from 255. No other clock raises the strobe.
- R5: The readable byte equals the line number of the previous clock with bits 1:0 forced to zero (the line number ANDed with 0xFC). It is one clock behind the line number.
- R6: The periodic interrupt line equals bit 5 of the current line number. It changes level only on lines that are multiples of 32.
- R7: The end-of-area interrupt line is the AND of line-number bits 7:4. It rises on line 240, stays high through line 255 and falls when the count wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | Line-rate advance enable |
| line_num | output | 8 | Current scanline number |
| vcount_rd | output | 8 | Registered readable byte, line number with bits 1:0 cleared |
| frame_start | output | 1 | One-clock strobe on wrap to line 0 |
| irq_toggle | output | 1 | Periodic interrupt source, line bit 5 |
| irq_end_area | output | 1 | End-of-visible-area interrupt source, lines 240 to 255 |

## Verification
The line number, the frame-start strobe and both interrupt lines all reflect a tick after the same single clock edge. The readable byte takes one more edge, because it copies the line number of the clock before. The bench drives the tick at the falling edge. At the next falling edge it compares every output with a model that is advanced once per edge and that keeps the line number of the previous clock for the byte, so each check lands in the cycle its result is due. The stimulus mixes runs of back-to-back ticks that cross several wraps, random tick gaps, and a reset asserted partway through a frame.

// File: rtl/raster_pkg.sv
package raster_pkg;

    localparam int RASTER_LINE_W    = 8;
    localparam int RASTER_TOGGLE_B  = 5;
    localparam int RASTER_END_BITS  = 4;
    localparam int RASTER_READ_DROP = 2;

    typedef struct packed {
        logic toggle;
        logic end_area;
    } raster_irq_t;

    // Clear the low bits that the read port does not carry.
    function automatic logic [RASTER_LINE_W-1:0] raster_read_mask(
        input logic [RASTER_LINE_W-1:0] line
    );
        logic [RASTER_LINE_W-1:0] m;
        m = line;
        for (int i = 0; i < RASTER_READ_DROP; i++) begin
            m[i] = 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/raster_line_counter.sv
module raster_line_counter
    import raster_pkg::*;
#(
    parameter int LINE_W = RASTER_LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic [LINE_W-1:0] line,
    output logic              wrap_pulse
);
    localparam logic [LINE_W-1:0] LAST_LINE = {LINE_W{1'b1}};

    logic [LINE_W-1:0] line_q;
    logic              wrap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= tick && (line_q == LAST_LINE);
            if (tick) begin
                line_q <= line_q + 1'b1;
            end
        end
    end

    assign line       = line_q;
    assign wrap_pulse = wrap_q;

    // R2: a tick below the last line adds exactly one
    a_r2_advance: assert property (@(posedge clk) disable iff (rst)
        (tick && line_q != LAST_LINE) |=> (line_q == $past(line_q) + 1'b1));
    // R2: without a tick the count holds
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(line_q));
    // R3: wrap from the last line to zero
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && line_q == LAST_LINE) |=> (line_q == '0));
    // R4: strobe only on line zero, never two clocks running
    a_r4_on_zero: assert property (@(posedge clk) disable iff (rst)
        wrap_q |-> (line_q == '0));
    a_r4_single: assert property (@(posedge clk) disable iff (rst)
        wrap_q |=> !wrap_q);
endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
    import raster_pkg::*;
#(
    parameter int LINE_W   = RASTER_LINE_W,
    parameter int TOGGLE_B = RASTER_TOGGLE_B,
    parameter int END_BITS = RASTER_END_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] line,
    output raster_irq_t       irq
);
    localparam int END_LINE = ((1 << END_BITS) - 1) << (LINE_W - END_BITS);
    localparam int PERIOD   = 1 << TOGGLE_B;

    logic end_flag;

    generate
        if (END_BITS > 0) begin : g_end
            assign end_flag = &line[LINE_W-1 -: END_BITS];
        end else begin : g_noend
            assign end_flag = 1'b0;
        end
    endgenerate

    assign irq.toggle   = line[TOGGLE_B];
    assign irq.end_area = end_flag;

    // R6: the toggle line moves only on multiples of its half period
    a_r6_edge_aligned: assert property (@(posedge clk) disable iff (rst)
        !$stable(irq.toggle) |-> ((int'(line) % PERIOD) == 0));
    // R7: end-of-area rises exactly on the first line of the band
    a_r7_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(irq.end_area) |-> (int'(line) == END_LINE));
    // R7: and falls only as the count returns to zero
    a_r7_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(irq.end_area) |-> (line == '0));
endmodule

// File: rtl/raster_readback.sv
module raster_readback
    import raster_pkg::*;
#(
    parameter int LINE_W = RASTER_LINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] line,
    output logic [LINE_W-1:0] rd_byte
);
    logic [LINE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= raster_read_mask(line);
        end
    end

    assign rd_byte = rd_q;

    // R5: dropped bits never read as one
    a_r5_low_clear: assert property (@(posedge clk) disable iff (rst)
        rd_q[RASTER_READ_DROP-1:0] == '0);
    // R5: upper bits follow the previous clock's line
    a_r5_lag: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rd_q[LINE_W-1:RASTER_READ_DROP] == $past(line[LINE_W-1:RASTER_READ_DROP])));
endmodule

// File: rtl/raster_timing.sv
module raster_timing
    import raster_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_tick,
    output logic [7:0] line_num,
    output logic [7:0] vcount_rd,
    output logic       frame_start,
    output logic       irq_toggle,
    output logic       irq_end_area
);
    logic [RASTER_LINE_W-1:0] line_w;
    raster_irq_t              irq_w;

    raster_line_counter #(.LINE_W(RASTER_LINE_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .tick       (line_tick),
        .line       (line_w),
        .wrap_pulse (frame_start)
    );

    raster_irq_gen #(
        .LINE_W   (RASTER_LINE_W),
        .TOGGLE_B (RASTER_TOGGLE_B),
        .END_BITS (RASTER_END_BITS)
    ) u_irq (
        .clk  (clk),
        .rst  (rst),
        .line (line_w),
        .irq  (irq_w)
    );

    raster_readback #(.LINE_W(RASTER_LINE_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .line    (line_w),
        .rd_byte (vcount_rd)
    );

    assign line_num     = line_w;
    assign irq_toggle   = irq_w.toggle;
    assign irq_end_area = irq_w.end_area;

    // R1: the clock after a reset edge shows a cleared unit
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (line_num == 8'd0 && vcount_rd == 8'd0 && !frame_start));
endmodule

// File: tb/raster_timing_bench.sv
module raster_timing_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_tick = 1'b0;
    logic [7:0] line_num, vcount_rd;
    logic       frame_start, irq_toggle, irq_end_area;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int frames_seen = 0;

    logic [7:0] m_line = 8'd0;
    logic [7:0] m_rd   = 8'd0;
    logic       m_fs   = 1'b0;

    always #10 clk = ~clk;

    raster_timing u_raster_timing (
        .clk          (clk),
        .rst          (rst),
        .line_tick    (line_tick),
        .line_num     (line_num),
        .vcount_rd    (vcount_rd),
        .frame_start  (frame_start),
        .irq_toggle   (irq_toggle),
        .irq_end_area (irq_end_area)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] l);
        return l & 8'hFC;
    endfunction

    function automatic logic exp_end(input logic [7:0] l);
        return (l >= 8'd240);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R2/R3 line", line_num, m_line);
        chk("R5 read byte", vcount_rd, m_rd);
        chk("R4 frame start", {7'd0, frame_start}, {7'd0, m_fs});
        chk("R6 toggle", {7'd0, irq_toggle}, {7'd0, m_line[5]});
        chk("R7 end area", {7'd0, irq_end_area}, {7'd0, exp_end(m_line)});
    endtask

    // Drive at negedge, advance the model for the coming edge, check at next negedge.
    task automatic cycle(input logic t, input logic r);
        line_tick = t;
        rst       = r;
        if (r) begin
            m_rd = 8'd0; m_fs = 1'b0; m_line = 8'd0;
        end else begin
            m_rd   = exp_read(m_line);
            m_fs   = t && (m_line == 8'd255);
            m_line = t ? m_line + 8'd1 : m_line;
        end
        @(posedge clk);
        @(negedge clk);
        if (m_fs) frames_seen++;
        check_all();
    endtask

    initial begin
        void'($urandom(32'd4242));
        cycle(1'b0, 1'b1);
        cycle(1'b1, 1'b1);
        // R1: reset state
        chk("R1 line after reset", line_num, 8'd0);
        chk("R1 byte after reset", vcount_rd, 8'd0);
        chk("R1 strobe after reset", {7'd0, frame_start}, 8'd0);
        // R2: idle clocks hold the count
        for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0);
        // R3, R4, R6, R7: back-to-back ticks across several frames
        for (int i = 0; i < 1100; i++) cycle(1'b1, 1'b0);
        // R2, R5: random tick gaps
        for (int i = 0; i < 1500; i++) cycle(logic'(($urandom % 3) != 0), 1'b0);
        // R1: reset partway through a frame
        while (m_line < 8'd245) cycle(1'b1, 1'b0);
        cycle(1'b1, 1'b1);
        chk("R1 mid-frame reset line", line_num, 8'd0);
        chk("R7 end area cleared by reset", {7'd0, irq_end_area}, 8'd0);
        for (int i = 0; i < 600; i++) cycle(logic'($urandom % 2), 1'b0);
        // R4: strobe must have fired on each observed wrap
        checks++;
        if (frames_seen < 4) begin
            errors++;
            $display("FAIL R4 frame count: actual %0d expected >= 4", frames_seen);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule